// File: doc/BRIEF.md
# Pseudoexhaustive Pattern Source with Parity-Derived Fourth Line

This block produces test vectors for a four-input circuit under test in which no output depends on more than two of the inputs. Three of the vector lines come directly from a three-stage autonomous linear feedback register. The fourth line is the even-parity sum of those three. It is computed combinationally and has no storage of its own. The register cycles through seven nonzero states. Over one period every pair of lines that a two-input cone can observe takes all four value combinations.

The block starts from the seed 100 (x1=1, x2=0, x3=0), either at reset or after a load. While `step_en` is high, the register advances once per clock. A load strobe writes a new three-bit seed instead. A second seed can therefore be used when a test needs one. A zero seed would lock the register, so the block substitutes the default seed for it. The control path decodes each cycle into one of four named actions. HOLD keeps the state. STEP applies the recurrence. LOAD writes the seed. RESEED writes the default seed in place of a zero seed. Reset forces the default seed. LOAD and RESEED take priority over STEP, and STEP takes priority over HOLD.

Top module: `lfsrx_pattern_gen`

## Requirements
- R1: One clock after synchronous reset has been high, the stages hold 100 and `pattern` reads 4'b1001. Bit 3 of `pattern` is x1, bit 2 is x2, bit 1 is x3 and bit 0 is x4.
- R2: On each clock edge where `step_en` is high and `seed_load` is low, the stages update as follows: x1 takes x1^x3, x2 takes x1^x2, and x3 takes the old x2. From 100 the emitted patterns are therefore 1001, 1100, 1010, 0101, 0110, 1111, 0011.
- R3: Seven steps from any nonzero state return the block to that state, and no shorter run of steps does so.
- R4: x4 always equals x1^x2^x3, so the four bits of `pattern` have even parity in every cycle. x4 follows a change in x1..x3 in the same cycle.
- R5: While `step_en` and `seed_load` are both low, `pattern` does not change.
- R6: When `seed_load` is high on a clock edge and `seed_val` is nonzero, the stages take `seed_val` (bit 2 to x1, bit 1 to x2, bit 0 to x3) on that edge. This happens whatever the value of `step_en`.
- R7: A load with `seed_val` equal to 000 writes the default seed 100 instead.
- R8: The stages never hold 000.
- R9: Within any seven consecutive patterns, each of the line pairs (x1,x3), (x1,x2), (x2,x3) and (x3,x4) shows all four value combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; loads the default seed |
| seed_load | input | 1 | Seed write strobe; takes priority over stepping |
| seed_val | input | 3 | Seed value, bit 2 to x1 down to bit 0 to x3 |
| step_en | input | 1 | Advance the register by one state this cycle |
| pattern | output | 4 | Test vector x1 x2 x3 x4, x1 in bit 3 |

## Verification
The bench walks the full period from the default seed and from every other nonzero seed. A wrong feedback tap would break the listed order or shorten the cycle. A swapped bit order would show up as mismatched patterns. It raises `step_en` together with a load strobe to catch a design that steps instead of loading. It also loads 000, because a design that accepts that value sticks at an all-zero, odd-coverage output. The parity line is checked in every sampled cycle, which exposes a registered or wrongly tapped x4 one cycle after each step. Each cone pair's coverage is measured over a period, so a net that drops a term leaves a combination missing.

// File: rtl/lfsrx_pkg.sv
package lfsrx_pkg;

    localparam int STAGES   = 3;
    localparam int PAT_W    = STAGES + 1;
    localparam int PERIOD   = (1 << STAGES) - 1;

    typedef logic [STAGES-1:0] stage_t;
    typedef logic [PAT_W-1:0]  pattern_t;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_STEP   = 2'd1,
        ACT_LOAD   = 2'd2,
        ACT_RESEED = 2'd3
    } act_e;

    // Bit STAGES-1 is x1, bit 0 is x3.
    function automatic stage_t advance(input stage_t s);
        stage_t n;
        n[2] = s[2] ^ s[0];
        n[1] = s[2] ^ s[1];
        n[0] = s[1];
        return n;
    endfunction

endpackage

// File: rtl/lfsrx_action_dec.sv
module lfsrx_action_dec
    import lfsrx_pkg::*;
(
    input  logic   seed_load,
    input  logic   seed_zero,
    input  logic   step_en,
    output act_e   act
);

    always_comb begin
        unique case ({seed_load, step_en})
            2'b10, 2'b11: act = seed_zero ? ACT_RESEED : ACT_LOAD;
            2'b01:        act = ACT_STEP;
            default:      act = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/lfsrx_stage_reg.sv
module lfsrx_stage_reg
    import lfsrx_pkg::*;
#(
    parameter stage_t SEED_DEFAULT = 3'b100
) (
    input  logic   clk,
    input  logic   rst,
    input  act_e   act,
    input  stage_t seed_val,
    output stage_t stages
);

    stage_t state_q;
    stage_t state_d;

    always_comb begin
        unique case (act)
            ACT_HOLD:   state_d = state_q;
            ACT_STEP:   state_d = advance(state_q);
            ACT_LOAD:   state_d = seed_val;
            ACT_RESEED: state_d = SEED_DEFAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEED_DEFAULT;
        else     state_q <= state_d;
    end

    always_comb begin
        stages = state_q;
    end

    AST_RESET_SEED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == SEED_DEFAULT)); // R1
    AST_SHIFT_X3: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_STEP) |=> (state_q[0] == $past(state_q[1]))); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_HOLD) |=> $stable(state_q)); // R5
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_LOAD) |=> (state_q == $past(seed_val))); // R6
    AST_ZERO_RESEED: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_RESEED) |=> (state_q == SEED_DEFAULT)); // R7
    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) || !$past(rst) |-> (state_q != '0)); // R8

endmodule

// File: rtl/lfsrx_parity_net.sv
module lfsrx_parity_net #(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] taps,
    output logic             sum
);

    logic [WIDTH:0] chain;
    assign chain[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_xor
        assign chain[i+1] = chain[i] ^ taps[i];
    end

    assign sum = chain[WIDTH];

endmodule

// File: rtl/lfsrx_pattern_gen.sv
module lfsrx_pattern_gen
    import lfsrx_pkg::*;
#(
    parameter stage_t SEED_DEFAULT = 3'b100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seed_load,
    input  logic [STAGES-1:0] seed_val,
    input  logic             step_en,
    output logic [PAT_W-1:0] pattern
);

    act_e   act;
    stage_t stages;
    logic   x4;

    lfsrx_action_dec u_dec (
        .seed_load (seed_load),
        .seed_zero (seed_val == '0),
        .step_en   (step_en),
        .act       (act)
    );

    lfsrx_stage_reg #(
        .SEED_DEFAULT (SEED_DEFAULT)
    ) u_reg (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .seed_val (seed_val),
        .stages   (stages)
    );

    lfsrx_parity_net #(
        .WIDTH (STAGES)
    ) u_net (
        .taps (stages),
        .sum  (x4)
    );

    always_comb begin
        pattern = {stages, x4};
    end

    AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst)
        (^pattern) == 1'b0); // R4

endmodule

// File: tb/lfsrx_pattern_gen_tb_top.sv
module lfsrx_pattern_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       seed_load = 1'b0;
    logic [2:0] seed_val = 3'b000;
    logic       step_en = 1'b0;
    logic [3:0] pattern;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // R2 sequence from seed 100, x1 in bit 3
    logic [3:0] exp_seq [7] = '{4'h9, 4'hC, 4'hA, 4'h5, 4'h6, 4'hF, 4'h3};

    always #2.5 clk = ~clk;

    lfsrx_pattern_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .seed_load (seed_load),
        .seed_val  (seed_val),
        .step_en   (step_en),
        .pattern   (pattern)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic parity_check();
        check("R4", {3'b000, ^pattern}, 4'h0);
    endtask

    function automatic int index_of(input logic [2:0] s);
        for (int k = 0; k < 7; k++) if (exp_seq[k][3:1] == s) return k;
        return -1;
    endfunction

    initial begin
        logic [3:0] seen [4];
        logic [3:0] start;
        tick();
        tick();
        rst = 1'b0;
        // R1
        check("R1", pattern, 4'b1001);
        parity_check();

        // R2 / R4 / R9: one period from default seed
        for (int p = 0; p < 4; p++) seen[p] = '0;
        step_en = 1'b1;
        for (int i = 0; i < 7; i++) begin
            check("R2", pattern, exp_seq[i]);
            parity_check();
            check("R8", {1'b0, pattern[3:1] == 3'b000 ? 3'b111 : 3'b000}, 4'h0);
            seen[0][{pattern[3], pattern[1]}] = 1'b1;
            seen[1][{pattern[3], pattern[2]}] = 1'b1;
            seen[2][{pattern[2], pattern[1]}] = 1'b1;
            seen[3][{pattern[1], pattern[0]}] = 1'b1;
            tick();
        end
        check("R3", pattern, 4'b1001);
        for (int p = 0; p < 4; p++) check("R9", seen[p], 4'hF);

        // R5: hold
        step_en = 1'b0;
        tick();
        start = pattern;
        for (int i = 0; i < 5; i++) begin
            tick();
            check("R5", pattern, start);
        end

        // R6 / R3: every nonzero seed, load with step_en high
        for (int s = 1; s < 8; s++) begin
            int k;
            seed_val  = 3'(s);
            seed_load = 1'b1;
            step_en   = 1'b1;
            tick();
            seed_load = 1'b0;
            check("R6", {pattern[3:1], 1'b0}, {3'(s), 1'b0});
            parity_check();
            k = index_of(3'(s));
            for (int i = 1; i <= 7; i++) begin
                tick();
                check("R2", pattern, exp_seq[(k + i) % 7]);
                if (i < 7) check("R3", {3'b000, pattern[3:1] == 3'(s)}, 4'h0);
            end
            check("R3", {pattern[3:1], 1'b0}, {3'(s), 1'b0});
        end

        // R7: zero seed becomes default
        step_en   = 1'b0;
        seed_val  = 3'b000;
        seed_load = 1'b1;
        tick();
        seed_load = 1'b0;
        check("R7", pattern, 4'b1001);
        step_en = 1'b1;
        tick();
        check("R7", pattern, 4'b1100);
        step_en = 1'b0;

        // R1: reset mid-sequence
        step_en = 1'b1;
        tick();
        tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R1", pattern, 4'b1001);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule